// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Core

This block is a small processor core that executes one instruction per clock over a fixed subset of a 32-bit load/store instruction set. The subset covers register-to-register add, subtract and signed compare, and immediate add, or and signed compare. It also has word and byte memory access, load-upper-immediate, equal and not-equal branches, direct jumps, jump-and-link and jump-through-register. The core holds the register file, the ALU, the instruction decoder and the next-PC logic. Memories live outside the block.

The program counter is a register that drives the instruction fetch address. The instruction word comes back in the same cycle. A separate data port gives a byte address, write data and four byte-lane write strobes, and it takes read data back in the same cycle. Every instruction completes at the next rising clock edge. There are no traps, no delay slots and no pipeline. Undefined encodings behave as no-operations.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC is loaded with `RESET_PC` (default 0). During reset `dmem_wstrb` stays 0 and no register is written, even when the fetched word is a store.
- R2: Register 0 always reads as zero. A write aimed at register 0 is dropped. Any other register, once written, returns the written value on the following cycles.
- R3: Opcode 0 selects the register format (rs = bits 25:21, rt = 20:16, rd = 15:11, function = 5:0). Function 32 writes rs+rt to rd, and function 34 writes rs-rt to rd. Both wrap modulo 2^32 with no trap.
- R4: Function 42 (register format) and opcode 10 (immediate format) write 1 to the destination when the first operand is less than the second as a signed value, and 0 otherwise. The immediate form sign-extends its 16-bit immediate (bits 15:0) and writes rt.
- R5: Opcode 8 writes rs plus the sign-extended immediate to rt. Opcode 13 writes rs OR the zero-extended immediate to rt.
- R6: Opcode 15 writes the immediate into bits 31:16 of rt and clears bits 15:0.
- R7: Opcode 35 loads the 32-bit word at rs + sign-extended offset into rt. Opcode 43 drives that address with rt as write data and all four strobes (`4'b1111`).
- R8: Opcode 32 reads the byte in lane addr[1:0] (lane k = data bits 8k+7:8k, little-endian) at rs + sign-extended offset, sign-extends it and writes it to rt.
- R9: Opcode 40 asserts only strobe bit addr[1:0], and that lane carries rt[7:0]. The other bytes of the memory word are unchanged.
- R10: Opcode 4 (branch when rs equals rt) and opcode 5 (branch when they differ) set the next PC to PC+4 + (sign-extended offset << 2) when taken, and to PC+4 otherwise. Backward offsets work.
- R11: Opcode 2 jumps to {(PC+4)[31:28], bits 25:0, 2'b00}. Opcode 3 jumps to the same target and writes PC+4 to register 31.
- R12: Register format with function 8 sets the next PC to the value of rs.
- R13: Any other opcode, or any other function under opcode 0, writes no register, asserts no strobe and advances the PC by 4. Every instruction that is not a branch or a jump advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Fetch byte address (the PC register) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Data byte address |
| dmem_wdata | output | 32 | Store data, with the byte replicated into every lane for byte stores |
| dmem_wstrb | output | 4 | Byte-lane write strobes; all zero means no write |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, same cycle |

## Verification
Small directed programs run from the instruction array. They place their results in the data array, where they are compared. Arithmetic uses mixed-sign operands and a wrap past the signed maximum, and separates add from subtract and sign from zero extension. Compares use negative against positive, equal operands and the edge of an immediate, which separates signed from unsigned and less-than from less-or-equal. Byte loads read all four lanes of a word whose bytes have distinct top bits, which exposes lane order and sign handling. Byte stores land next to preset words that must stay unchanged. Branch programs include a skip, a fall-through and a counted backward loop. Jump programs link and return, and they cross into a high address region where the kept upper PC bits become visible at the fetch port.

// File: rtl/sc_core_pkg.sv
`timescale 1ns/1ps
package sc_core_pkg;

  localparam int unsigned XLEN   = 32;
  localparam int unsigned RIDX_W = 5;

  // primary opcodes (bits 31:26)
  localparam logic [5:0] OP_RFMT = 6'd0;
  localparam logic [5:0] OP_J    = 6'd2;
  localparam logic [5:0] OP_JAL  = 6'd3;
  localparam logic [5:0] OP_BEQ  = 6'd4;
  localparam logic [5:0] OP_BNE  = 6'd5;
  localparam logic [5:0] OP_ADDI = 6'd8;
  localparam logic [5:0] OP_SLTI = 6'd10;
  localparam logic [5:0] OP_ORI  = 6'd13;
  localparam logic [5:0] OP_LUI  = 6'd15;
  localparam logic [5:0] OP_LB   = 6'd32;
  localparam logic [5:0] OP_LW   = 6'd35;
  localparam logic [5:0] OP_SB   = 6'd40;
  localparam logic [5:0] OP_SW   = 6'd43;

  // function codes under OP_RFMT
  localparam logic [5:0] FN_JR  = 6'd8;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_SLT, ALU_OR, ALU_LUI
  } alu_op_e;

  typedef enum logic [1:0] {
    DST_NONE, DST_RT, DST_RD, DST_LINK
  } dst_e;

  typedef struct packed {
    dst_e    dst;
    alu_op_e alu_op;
    logic    use_imm;
    logic    zext_imm;
    logic    ld_word;
    logic    ld_byte;
    logic    st_word;
    logic    st_byte;
    logic    br_eq;
    logic    br_ne;
    logic    jmp;
    logic    jmp_reg;
  } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
`timescale 1ns/1ps
module sc_decode
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl          = '0;
    ctrl.dst      = DST_NONE;
    ctrl.alu_op   = ALU_ADD;
    case (opcode)
      OP_RFMT: begin
        case (funct)
          FN_ADD: begin ctrl.dst = DST_RD; ctrl.alu_op = ALU_ADD; end
          FN_SUB: begin ctrl.dst = DST_RD; ctrl.alu_op = ALU_SUB; end
          FN_SLT: begin ctrl.dst = DST_RD; ctrl.alu_op = ALU_SLT; end
          FN_JR:  ctrl.jmp_reg = 1'b1;
          default: ;
        endcase
      end
      OP_ADDI: begin ctrl.dst = DST_RT; ctrl.use_imm = 1'b1; end
      OP_SLTI: begin ctrl.dst = DST_RT; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_SLT; end
      OP_ORI: begin
        ctrl.dst = DST_RT; ctrl.use_imm = 1'b1; ctrl.zext_imm = 1'b1; ctrl.alu_op = ALU_OR;
      end
      OP_LUI:  begin ctrl.dst = DST_RT; ctrl.use_imm = 1'b1; ctrl.alu_op = ALU_LUI; end
      OP_LW:   begin ctrl.dst = DST_RT; ctrl.use_imm = 1'b1; ctrl.ld_word = 1'b1; end
      OP_LB:   begin ctrl.dst = DST_RT; ctrl.use_imm = 1'b1; ctrl.ld_byte = 1'b1; end
      OP_SW:   begin ctrl.use_imm = 1'b1; ctrl.st_word = 1'b1; end
      OP_SB:   begin ctrl.use_imm = 1'b1; ctrl.st_byte = 1'b1; end
      OP_BEQ:  ctrl.br_eq = 1'b1;
      OP_BNE:  ctrl.br_ne = 1'b1;
      OP_J:    ctrl.jmp = 1'b1;
      OP_JAL:  begin ctrl.jmp = 1'b1; ctrl.dst = DST_LINK; end
      default: ;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);

  localparam int unsigned HALF = W / 2;

  logic [W-1:0] diff;
  logic         lt_signed;

  assign diff      = a - b;
  // signed less-than from the subtraction and the operand signs
  assign lt_signed = (a[W-1] != b[W-1]) ? a[W-1] : diff[W-1];

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(W-1){1'b0}}, lt_signed};
      ALU_OR:  y = a | b;
      ALU_LUI: y = {b[HALF-1:0], {HALF{1'b0}}};
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
  parameter int unsigned W      = 32,
  parameter int unsigned NREGS  = 32,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] wa,
  input  logic [W-1:0]     wd,
  input  logic [IDX_W-1:0] ra_a,
  output logic [W-1:0]     rd_a,
  input  logic [IDX_W-1:0] ra_b,
  output logic [W-1:0]     rd_b
);

  logic [W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (we && wa != '0) regs[wa] <= wd;
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

  // R2
  reg_readback_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && $past(wa) != '0 && ra_a == $past(wa)) |-> rd_a == $past(wd));

  // R2
  reg_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && $past(wa) == '0 && ra_b == '0) |-> rd_b == '0);

endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
  import sc_core_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  parameter int unsigned NREGS    = 32,
  parameter int unsigned LINK_REG = 31
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic [3:0]  dmem_wstrb,
  input  logic [31:0] dmem_rdata
);

  localparam int unsigned LANES = XLEN / 8;
  localparam int unsigned LSB_W = $clog2(LANES);

  logic [XLEN-1:0]   pc_q, pc_plus4, pc_next, br_target, jmp_target;
  logic [XLEN-1:0]   rs_val, rt_val, imm_ext, alu_b, alu_y, wb_data, ld_byte_ext;
  logic [RIDX_W-1:0] rs, rt, rd, wa;
  logic [15:0]       imm16;
  logic              rf_we, take_br;
  logic [7:0]        lane_byte [LANES];
  logic [7:0]        sel_byte;
  logic              unused_bits;
  ctrl_t             ctrl;

  assign rs    = imem_rdata[25:21];
  assign rt    = imem_rdata[20:16];
  assign rd    = imem_rdata[15:11];
  assign imm16 = imem_rdata[15:0];
  assign unused_bits = ^{imem_rdata[10:6], imm_ext[31:30]};

  sc_decode u_dec (
    .opcode (imem_rdata[31:26]),
    .funct  (imem_rdata[5:0]),
    .ctrl   (ctrl)
  );

  sc_regfile #(.W(XLEN), .NREGS(NREGS)) u_rf (
    .clk  (clk),
    .rst  (rst),
    .we   (rf_we),
    .wa   (wa),
    .wd   (wb_data),
    .ra_a (rs),
    .rd_a (rs_val),
    .ra_b (rt),
    .rd_b (rt_val)
  );

  assign imm_ext = ctrl.zext_imm ? {16'h0000, imm16} : {{16{imm16[15]}}, imm16};
  assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a  (rs_val),
    .b  (alu_b),
    .op (ctrl.alu_op),
    .y  (alu_y)
  );

  // data port: byte lanes, little-endian
  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign lane_byte[k] = dmem_rdata[8*k +: 8];
    end
  endgenerate

  assign sel_byte    = lane_byte[alu_y[LSB_W-1:0]];
  assign ld_byte_ext = {{(XLEN-8){sel_byte[7]}}, sel_byte};
  assign dmem_addr   = alu_y;
  assign dmem_wdata  = ctrl.st_byte ? {LANES{rt_val[7:0]}} : rt_val;

  always_comb begin
    dmem_wstrb = '0;
    if (!rst) begin
      if (ctrl.st_word)      dmem_wstrb = '1;
      else if (ctrl.st_byte) dmem_wstrb = 4'(1) << alu_y[LSB_W-1:0];
    end
  end

  // write-back
  always_comb begin
    case (ctrl.dst)
      DST_RT:   wa = rt;
      DST_RD:   wa = rd;
      DST_LINK: wa = RIDX_W'(LINK_REG);
      default:  wa = '0;
    endcase
  end

  assign rf_we   = (ctrl.dst != DST_NONE) && !rst;
  assign wb_data = (ctrl.dst == DST_LINK) ? pc_plus4   :
                   ctrl.ld_word           ? dmem_rdata :
                   ctrl.ld_byte           ? ld_byte_ext : alu_y;

  // next PC
  assign pc_plus4   = pc_q + 32'd4;
  assign br_target  = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign jmp_target = {pc_plus4[31:28], imem_rdata[25:0], 2'b00};
  assign take_br    = (ctrl.br_eq && (rs_val == rt_val)) ||
                      (ctrl.br_ne && (rs_val != rt_val));

  always_comb begin
    if (ctrl.jmp_reg)  pc_next = rs_val;
    else if (ctrl.jmp) pc_next = jmp_target;
    else if (take_br)  pc_next = br_target;
    else               pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_next;
  end

  assign imem_addr = pc_q;

  // R13
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ctrl.br_eq || ctrl.br_ne || ctrl.jmp || ctrl.jmp_reg))
      |-> imem_addr == $past(imem_addr) + 32'd4);

  // R9
  sb_lane_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.st_byte |-> ($countones(dmem_wstrb) == 1 &&
                      dmem_wdata[8*dmem_addr[1:0] +: 8] == rt_val[7:0]));

  // R13
  no_store_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.st_word || ctrl.st_byte) |-> dmem_wstrb == 4'b0000);

  // R4
  slt_bool_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.alu_op == ALU_SLT) |-> alu_y[31:1] == '0);

  // R6
  lui_low_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.alu_op == ALU_LUI) |-> alu_y[15:0] == 16'h0000);

endmodule

// File: tb/test_sc_core.sv
`timescale 1ns/1ps
module test_sc_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic [3:0]  dmem_wstrb;

  logic [31:0] imem [1024];
  logic [31:0] dmem [1024];
  int tests  = 0;
  int errors = 0;
  int wr_cnt = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sc_core i_sc_core (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_wstrb (dmem_wstrb),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[11:2]];
  assign dmem_rdata = dmem[dmem_addr[11:2]];

  always @(posedge clk) begin
    if (dmem_wstrb != 4'b0000) begin
      wr_cnt <= wr_cnt + 1;
      for (int k = 0; k < 4; k++)
        if (dmem_wstrb[k]) dmem[dmem_addr[11:2]][8*k +: 8] <= dmem_wdata[8*k +: 8];
    end
  end

  function automatic logic [31:0] enc_r(input int s, input int t, input int d, input int fn);
    return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(input int op, input int s, input int t, input int imm);
    return {6'(op), 5'(s), 5'(t), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(input int op, input int idx);
    return {6'(op), 26'(idx)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int k = 0; k < 1024; k++) begin
      imem[k] = 32'h0;
      dmem[k] = 32'h0;
    end
  endtask

  task automatic run_prog(input int cycles);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    wr_cnt = 0;
    rst = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  // R1
  task automatic t_reset();
    clear_mem();
    imem[0] = enc_j(2, 5);
    imem[5] = enc_j(2, 5);
    run_prog(4);
    chk("R1 pre-reset pc parked", imem_addr, 32'h14);
    imem[0] = enc_i(43, 0, 0, 16'h0700);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 pc after reset edge", imem_addr, 32'h0);
    chk("R1 no strobe in reset", {28'h0, dmem_wstrb}, 32'h0);
    @(negedge clk);
    chk("R1 store suppressed", dmem[32'h700 >> 2], 32'h0);
  endtask

  // R2 R3 R5 R6
  task automatic t_arith();
    clear_mem();
    imem[0]  = enc_i(8, 0, 1, 100);
    imem[1]  = enc_i(8, 0, 2, -7);
    imem[2]  = enc_r(1, 2, 3, 32);
    imem[3]  = enc_r(2, 1, 4, 34);
    imem[4]  = enc_i(13, 0, 5, 16'h8001);
    imem[5]  = enc_i(15, 0, 6, 16'h1234);
    imem[6]  = enc_i(8, 0, 0, 55);
    imem[7]  = enc_r(0, 0, 7, 32);
    imem[8]  = enc_i(15, 0, 8, 16'h7FFF);
    imem[9]  = enc_i(13, 8, 8, 16'hFFFF);
    imem[10] = enc_i(8, 8, 9, 1);
    imem[11] = enc_i(43, 0, 3, 16'h100);
    imem[12] = enc_i(43, 0, 4, 16'h104);
    imem[13] = enc_i(43, 0, 5, 16'h108);
    imem[14] = enc_i(43, 0, 6, 16'h10C);
    imem[15] = enc_i(43, 0, 7, 16'h110);
    imem[16] = enc_i(43, 0, 9, 16'h114);
    imem[17] = enc_j(2, 17);
    run_prog(40);
    chk("R3 add mixed sign", dmem[32'h100 >> 2], 32'd93);
    chk("R3 sub negative", dmem[32'h104 >> 2], 32'hFFFF_FF95);
    chk("R5 ori zero-extends", dmem[32'h108 >> 2], 32'h0000_8001);
    chk("R6 lui upper half", dmem[32'h10C >> 2], 32'h1234_0000);
    chk("R2 r0 write dropped", dmem[32'h110 >> 2], 32'h0);
    chk("R5 addi wraps at max", dmem[32'h114 >> 2], 32'h8000_0000);
  endtask

  // R4
  task automatic t_compare();
    clear_mem();
    imem[0]  = enc_i(8, 0, 1, -5);
    imem[1]  = enc_i(8, 0, 2, 3);
    imem[2]  = enc_r(1, 2, 3, 42);
    imem[3]  = enc_r(2, 1, 4, 42);
    imem[4]  = enc_r(1, 1, 5, 42);
    imem[5]  = enc_i(10, 1, 6, -4);
    imem[6]  = enc_i(10, 2, 7, 3);
    imem[7]  = enc_i(10, 2, 8, 4);
    for (int k = 0; k < 6; k++) imem[8+k] = enc_i(43, 0, 3+k, 16'h200 + 4*k);
    imem[14] = enc_j(2, 14);
    run_prog(40);
    chk("R4 slt neg<pos", dmem[32'h200 >> 2], 32'd1);
    chk("R4 slt pos<neg", dmem[32'h204 >> 2], 32'd0);
    chk("R4 slt equal", dmem[32'h208 >> 2], 32'd0);
    chk("R4 slti -5<-4", dmem[32'h20C >> 2], 32'd1);
    chk("R4 slti 3<3", dmem[32'h210 >> 2], 32'd0);
    chk("R4 slti 3<4", dmem[32'h214 >> 2], 32'd1);
  endtask

  // R7 R8 R9
  task automatic t_mem();
    clear_mem();
    dmem[32'h200 >> 2] = 32'h80C1_7F23;
    dmem[32'h310 >> 2] = 32'hAAAA_AAAA;
    dmem[32'h314 >> 2] = 32'h5A5A_5A5A;
    imem[0]  = enc_i(8, 0, 1, 16'h204);
    imem[1]  = enc_i(35, 1, 2, -4);
    imem[2]  = enc_i(32, 1, 3, -4);
    imem[3]  = enc_i(32, 1, 4, -3);
    imem[4]  = enc_i(32, 1, 5, -2);
    imem[5]  = enc_i(32, 1, 6, -1);
    imem[6]  = enc_i(43, 0, 2, 16'h300);
    imem[7]  = enc_i(43, 0, 3, 16'h304);
    imem[8]  = enc_i(43, 0, 4, 16'h308);
    imem[9]  = enc_i(43, 0, 5, 16'h30C);
    imem[10] = enc_i(43, 0, 6, 16'h320);
    imem[11] = enc_i(8, 0, 7, 16'h1234);
    imem[12] = enc_i(40, 0, 7, 16'h311);
    imem[13] = enc_i(40, 0, 5, 16'h313);
    imem[14] = enc_j(2, 14);
    run_prog(40);
    chk("R7 lw negative offset", dmem[32'h300 >> 2], 32'h80C1_7F23);
    chk("R8 lb lane0", dmem[32'h304 >> 2], 32'h0000_0023);
    chk("R8 lb lane1", dmem[32'h308 >> 2], 32'h0000_007F);
    chk("R8 lb lane2 sign", dmem[32'h30C >> 2], 32'hFFFF_FFC1);
    chk("R8 lb lane3 sign", dmem[32'h320 >> 2], 32'hFFFF_FF80);
    chk("R9 sb lanes 1 and 3", dmem[32'h310 >> 2], 32'hC1AA_34AA);
    chk("R9 sb neighbour kept", dmem[32'h314 >> 2], 32'h5A5A_5A5A);
  endtask

  // R10
  task automatic t_branch();
    clear_mem();
    imem[0]  = enc_i(8, 0, 3, 0);
    imem[1]  = enc_i(8, 0, 1, 5);
    imem[2]  = enc_i(8, 0, 2, 5);
    imem[3]  = enc_i(4, 1, 2, 2);
    imem[4]  = enc_i(8, 0, 3, 1);
    imem[5]  = enc_i(8, 0, 3, 2);
    imem[6]  = enc_i(5, 1, 2, 1);
    imem[7]  = enc_i(8, 0, 4, 9);
    imem[8]  = enc_i(8, 0, 5, 0);
    imem[9]  = enc_i(8, 5, 5, 1);
    imem[10] = enc_i(5, 5, 2, -2);
    imem[11] = enc_i(43, 0, 3, 16'h400);
    imem[12] = enc_i(43, 0, 4, 16'h404);
    imem[13] = enc_i(43, 0, 5, 16'h408);
    imem[14] = enc_i(4, 0, 0, -1);
    run_prog(60);
    chk("R10 beq taken skips", dmem[32'h400 >> 2], 32'd0);
    chk("R10 bne falls through", dmem[32'h404 >> 2], 32'd9);
    chk("R10 backward loop count", dmem[32'h408 >> 2], 32'd5);
    chk("R10 self branch holds pc", imem_addr, 32'h38);
  endtask

  // R11 R12
  task automatic t_jump();
    clear_mem();
    imem[0]  = enc_i(8, 0, 2, 0);
    imem[1]  = enc_j(3, 12);
    imem[2]  = enc_i(43, 0, 2, 16'h500);
    imem[3]  = enc_i(43, 0, 31, 16'h504);
    imem[4]  = enc_i(15, 0, 9, 16'h1000);
    imem[5]  = enc_i(13, 9, 9, 16'h0024);
    imem[6]  = enc_r(9, 0, 0, 8);
    imem[9]  = enc_j(2, 11);
    imem[10] = enc_i(8, 0, 10, 1);
    imem[11] = enc_j(2, 11);
    imem[12] = enc_i(8, 0, 2, 77);
    imem[13] = enc_r(31, 0, 0, 8);
    run_prog(40);
    chk("R11 jal target body ran", dmem[32'h500 >> 2], 32'd77);
    chk("R11 jal links pc+4", dmem[32'h504 >> 2], 32'd8);
    chk("R11 R12 upper pc bits kept", imem_addr, 32'h1000_002C);
  endtask

  // R13 R2
  task automatic t_nop();
    clear_mem();
    imem[0] = enc_i(8, 0, 1, 33);
    imem[1] = enc_i(63, 0, 1, 16'h0055);
    imem[2] = enc_r(1, 1, 1, 37);
    imem[3] = enc_r(0, 0, 1, 0);
    imem[4] = enc_i(43, 0, 1, 16'h600);
    imem[5] = enc_i(8, 0, 0, 9);
    imem[6] = enc_i(43, 0, 0, 16'h604);
    imem[7] = enc_j(2, 7);
    run_prog(30);
    chk("R13 unknown ops write nothing", dmem[32'h600 >> 2], 32'd33);
    chk("R2 r0 stays zero", dmem[32'h604 >> 2], 32'd0);
    chk("R13 only the two stores", wr_cnt, 32'd2);
    chk("R13 pc steps to halt", imem_addr, 32'h1C);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, errors);
      $finish;
    end
  end

  initial begin
    clear_mem();
    @(negedge clk);
    t_reset();
    t_arith();
    t_compare();
    t_mem();
    t_branch();
    t_jump();
    t_nop();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, errors);
    $finish;
  end

endmodule